// File: doc/BRIEF.md
# Block CRC-32 Framer and Checker

This block guards fixed-length data blocks carried over a byte-wide parallel link. It uses a 32-bit cyclic redundancy code over every data byte, so it replaces parity on single bytes. The transmit half takes a byte stream in which a start flag marks the first byte of a block and an end flag marks the last one. It forwards the data and then inserts the four check bytes directly behind the final data byte.

The receive half takes the same framing. It runs the same code over the incoming data bytes and treats the four bytes after the end flag as the received check field. It then gives its verdict on the block as a single-cycle accept or reject pulse. A block also gets a reject when its data length differs from the configured length, even if the check field matches.

Top module: `blk_crc_link`

## Requirements
- R1: The code uses generator 0x04C11DB7 and is preset to 0xFFFFFFFF. Each byte is taken bit 7 first, and the final value is not inverted. It covers every data byte of a block, from the start-flagged byte through the end-flagged byte.
- R2: The transmit half presents each accepted data byte on its output one clock after acceptance. The start and end flags travel with the byte, and the check-byte flag is low.
- R3: In the four clocks right after the end-flagged data byte is presented, the transmit output carries the 32-bit code most significant byte first, with the check-byte flag high. The source must keep tx_valid low during those four clocks.
- R4: A byte that carries the start flag presets the code register before the byte is folded in. On the receive side this applies in any phase and throws away any partial block.
- R5: On the receive side, the first four valid bytes after the end-flagged byte form the check field, most significant byte first. Exactly one clock after the fourth such byte is sampled, rx_ack or rx_nak pulses for one clock, and never both. rx_ack means the field equals the computed code and the length is correct.
- R6: If the data byte count at the end flag differs from DATA_BYTES (shorter or longer), the result is rx_nak.
- R7: While no block is open, receive bytes without the start flag are ignored, and so are cycles with rx_valid low. Neither produces a pulse or disturbs the next block.
- R8: Any single-bit or double-bit error anywhere in the data or the check field of a block of correct length gives rx_nak.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Transmit data byte present |
| tx_sob | input | 1 | Transmit byte is first of block |
| tx_eob | input | 1 | Transmit byte is last data byte of block |
| tx_byte | input | 8 | Transmit data byte |
| txo_valid | output | 1 | Output byte present |
| txo_sob | output | 1 | Output byte is first of block |
| txo_eob | output | 1 | Output byte is last data byte |
| txo_crc | output | 1 | Output byte belongs to the check field |
| txo_byte | output | 8 | Output byte |
| rx_valid | input | 1 | Receive byte present |
| rx_sob | input | 1 | Receive byte is first of block |
| rx_eob | input | 1 | Receive byte is last data byte |
| rx_byte | input | 8 | Receive byte |
| rx_ack | output | 1 | Block accepted pulse |
| rx_nak | output | 1 | Block rejected pulse |

## Verification
The transmit assertions assume that the source respects the four-cycle gap after an end-flagged byte. Every transmit sequence in the stimulus goes idle right after the last data byte and stays idle until the check field has left. The receive assertions assume nothing about framing: sequences that restart mid-block, stray bytes with no open block, and short or long blocks all keep within what they check. The sweep flips each bit and selected bit pairs of a small four-byte frame. Expected codes come from an independently written bit-serial model in the bench.

// File: rtl/blk_crc_pkg.sv
package blk_crc_pkg;

    localparam int          CRC_W     = 32;
    localparam int          CRC_BYTES = CRC_W / 8;
    localparam logic [31:0] CRC_POLY  = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED  = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DATA  = 2'd1,
        PH_CHECK = 2'd2
    } rx_phase_e;

    typedef struct packed {
        logic       valid;
        logic       sob;
        logic       eob;
        logic       is_crc;
        logic [7:0] data;
    } tx_beat_t;

    // Fold one byte into the running code, bit 7 first.
    function automatic logic [31:0] crc_step8(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[31] ^ d[i];
            r  = {r[30:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

endpackage

// File: rtl/crc_accum.sv
module crc_accum
    import blk_crc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic        preset,
    input  logic [7:0]  din,
    output logic [31:0] crc_q,
    output logic [31:0] crc_nxt
);

    always_comb crc_nxt = crc_step8(preset ? CRC_SEED : crc_q, din);

    always_ff @(posedge clk) begin
        if (rst)     crc_q <= CRC_SEED;
        else if (en) crc_q <= crc_nxt;
    end

endmodule

// File: rtl/blk_crc_tx.sv
module blk_crc_tx
    import blk_crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sob,
    input  logic       in_eob,
    input  logic [7:0] in_byte,
    output tx_beat_t   beat
);

    localparam int LW = $clog2(CRC_BYTES + 1);

    logic [31:0]   crc_q, crc_nxt;
    logic [31:0]   shift_q;
    logic [LW-1:0] left_q;
    tx_beat_t      beat_q;

    crc_accum u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (in_valid),
        .preset  (in_sob),
        .din     (in_byte),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            left_q  <= '0;
            shift_q <= '0;
        end else if (in_valid) begin
            beat_q <= '{valid: 1'b1, sob: in_sob, eob: in_eob, is_crc: 1'b0, data: in_byte};
            if (in_eob) begin
                left_q  <= LW'(CRC_BYTES);
                shift_q <= crc_nxt;
            end
        end else if (left_q != '0) begin
            beat_q  <= '{valid: 1'b1, sob: 1'b0, eob: 1'b0, is_crc: 1'b1, data: shift_q[31:24]};
            shift_q <= {shift_q[23:0], 8'h00};
            left_q  <= left_q - 1'b1;
        end else begin
            beat_q <= '0;
        end
    end

    assign beat = beat_q;

    // R3
    tx_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (left_q != '0) |-> !in_valid);

    // R2
    tx_pass_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (beat_q.valid && !beat_q.is_crc && beat_q.data == $past(in_byte)));

    // R3
    tx_append_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_q.valid && beat_q.eob && !beat_q.is_crc) |=> (beat_q.valid && beat_q.is_crc));

endmodule

// File: rtl/blk_crc_rx.sv
module blk_crc_rx
    import blk_crc_pkg::*;
#(
    parameter int DATA_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic       in_sob,
    input  logic       in_eob,
    input  logic [7:0] in_byte,
    output logic       ack,
    output logic       nak
);

    localparam int            CW  = $clog2(DATA_BYTES + 2);
    localparam logic [CW-1:0] LEN = CW'(DATA_BYTES);
    localparam logic [CW-1:0] SAT = CW'(DATA_BYTES + 1);
    localparam int            IW  = $clog2(CRC_BYTES);
    localparam logic [IW-1:0] LAST_IDX = IW'(CRC_BYTES - 1);

    rx_phase_e     phase_q;
    logic [CW-1:0] cnt_q, cnt_nxt;
    logic          len_ok_q;
    logic [IW-1:0] idx_q;
    logic [23:0]   rcv_q;
    logic [31:0]   crc_q, crc_nxt;
    logic          eng_en;
    logic          data_take;

    assign data_take = in_valid && (in_sob || phase_q == PH_DATA);
    assign eng_en    = data_take;

    crc_accum u_acc (
        .clk     (clk),
        .rst     (rst),
        .en      (eng_en),
        .preset  (in_sob),
        .din     (in_byte),
        .crc_q   (crc_q),
        .crc_nxt (crc_nxt)
    );

    always_comb begin
        if (in_sob)          cnt_nxt = CW'(1);
        else if (cnt_q == SAT) cnt_nxt = cnt_q;
        else                 cnt_nxt = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            cnt_q    <= '0;
            len_ok_q <= 1'b0;
            idx_q    <= '0;
            rcv_q    <= '0;
            ack      <= 1'b0;
            nak      <= 1'b0;
        end else begin
            ack <= 1'b0;
            nak <= 1'b0;
            if (data_take) begin
                cnt_q <= cnt_nxt;
                if (in_eob) begin
                    phase_q  <= PH_CHECK;
                    len_ok_q <= (cnt_nxt == LEN);
                    idx_q    <= '0;
                end else begin
                    phase_q <= PH_DATA;
                end
            end else if (in_valid && phase_q == PH_CHECK) begin
                rcv_q <= {rcv_q[15:0], in_byte};
                idx_q <= idx_q + 1'b1;
                if (idx_q == LAST_IDX) begin
                    phase_q <= PH_IDLE;
                    if (len_ok_q && ({rcv_q, in_byte} == crc_q)) ack <= 1'b1;
                    else                                         nak <= 1'b1;
                end
            end
        end
    end

    // R5
    rx_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ack, nak}));

    // R5
    rx_when_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sob && phase_q == PH_CHECK && idx_q == LAST_IDX) |=> (ack || nak));

    // R5
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (ack || nak) |=> !(ack || nak));

    // R6
    rx_len_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sob && phase_q == PH_CHECK && idx_q == LAST_IDX && !len_ok_q) |=> nak);

    // R7
    rx_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_IDLE && !(in_valid && in_sob)) |=> (phase_q == PH_IDLE && !ack && !nak));

endmodule

// File: rtl/blk_crc_link.sv
module blk_crc_link
    import blk_crc_pkg::*;
#(
    parameter int DATA_BYTES = 512
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_valid,
    input  logic       tx_sob,
    input  logic       tx_eob,
    input  logic [7:0] tx_byte,
    output logic       txo_valid,
    output logic       txo_sob,
    output logic       txo_eob,
    output logic       txo_crc,
    output logic [7:0] txo_byte,
    input  logic       rx_valid,
    input  logic       rx_sob,
    input  logic       rx_eob,
    input  logic [7:0] rx_byte,
    output logic       rx_ack,
    output logic       rx_nak
);

    tx_beat_t beat;

    blk_crc_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tx_valid),
        .in_sob   (tx_sob),
        .in_eob   (tx_eob),
        .in_byte  (tx_byte),
        .beat     (beat)
    );

    assign txo_valid = beat.valid;
    assign txo_sob   = beat.sob;
    assign txo_eob   = beat.eob;
    assign txo_crc   = beat.is_crc;
    assign txo_byte  = beat.data;

    blk_crc_rx #(.DATA_BYTES(DATA_BYTES)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .in_valid (rx_valid),
        .in_sob   (rx_sob),
        .in_eob   (rx_eob),
        .in_byte  (rx_byte),
        .ack      (rx_ack),
        .nak      (rx_nak)
    );

endmodule

// File: tb/sim_blk_crc_link.sv
module sim_blk_crc_link;

    localparam int NB = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_valid = 1'b0, tx_sob = 1'b0, tx_eob = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       txo_valid, txo_sob, txo_eob, txo_crc;
    logic [7:0] txo_byte;
    logic       rx_valid = 1'b0, rx_sob = 1'b0, rx_eob = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_ack, rx_nak;

    int checks = 0;
    int fails  = 0;
    logic [7:0] dbuf [0:15];

    always #5 clk = ~clk;

    blk_crc_link #(.DATA_BYTES(NB)) u0 (
        .clk(clk), .rst(rst),
        .tx_valid(tx_valid), .tx_sob(tx_sob), .tx_eob(tx_eob), .tx_byte(tx_byte),
        .txo_valid(txo_valid), .txo_sob(txo_sob), .txo_eob(txo_eob),
        .txo_crc(txo_crc), .txo_byte(txo_byte),
        .rx_valid(rx_valid), .rx_sob(rx_sob), .rx_eob(rx_eob), .rx_byte(rx_byte),
        .rx_ack(rx_ack), .rx_nak(rx_nak)
    );

    // Reference code: whole byte folded into the top, then eight shifts.
    function automatic logic [31:0] ref_crc(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int j = 0; j < n; j++) begin
            c = c ^ {dbuf[j], 24'h0};
            for (int k = 0; k < 8; k++)
                c = c[31] ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
        end
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fill(input int p);
        for (int j = 0; j < 16; j++)
            case (p)
                0: dbuf[j] = 8'(j + 1);
                1: dbuf[j] = 8'h00;
                2: dbuf[j] = 8'hFF;
                default: dbuf[j] = (j % 2 == 0) ? 8'hA5 : 8'h5A;
            endcase
    endtask

    // R1 R2 R3: send n bytes on the transmit side and follow the output
    task automatic tx_block(input int n);
        logic [31:0] exp = ref_crc(n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i > 0)
                check(txo_valid && !txo_crc && txo_byte == dbuf[i-1] && txo_sob == (i == 1),
                      "R2", {txo_valid, txo_crc, txo_byte}, {2'b10, dbuf[i-1]});
            tx_valid = 1'b1; tx_sob = (i == 0); tx_eob = (i == n - 1); tx_byte = dbuf[i];
        end
        @(negedge clk);
        check(txo_valid && !txo_crc && txo_eob && txo_byte == dbuf[n-1],
              "R2", {txo_valid, txo_crc, txo_eob, txo_byte}, {3'b101, dbuf[n-1]});
        tx_valid = 1'b0; tx_sob = 1'b0; tx_eob = 1'b0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(txo_valid && txo_crc && txo_byte == exp[31 - 8*k -: 8],
                  "R1 R3", {txo_valid, txo_crc, txo_byte}, {2'b11, exp[31 - 8*k -: 8]});
        end
        @(negedge clk);
        check(!txo_valid, "R3", txo_valid, 0);
    endtask

    // R5: n data bytes plus field, optional bit flips f1/f2 (-1 = none)
    task automatic rx_frame(input int n, input int f1, input int f2, input int gap, input bit exp_ack,
                            input string req);
        logic [31:0] c = ref_crc(n);
        logic [7:0]  b;
        bit          early = 1'b0;
        for (int j = 0; j < n + 4; j++) begin
            b = (j < n) ? dbuf[j] : c[31 - 8*(j - n) -: 8];
            if (f1 >= 0 && j == f1 / 8) b = b ^ (8'h01 << (f1 % 8));
            if (f2 >= 0 && j == f2 / 8) b = b ^ (8'h01 << (f2 % 8));
            @(negedge clk);
            if (rx_ack || rx_nak) early = 1'b1;
            if (gap != 0 && j > 0) begin
                rx_valid = 1'b0;
                @(negedge clk);
                if (rx_ack || rx_nak) early = 1'b1;
            end
            rx_valid = 1'b1; rx_sob = (j == 0); rx_eob = (j == n - 1); rx_byte = b;
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sob = 1'b0; rx_eob = 1'b0;
        check(!early && rx_ack == exp_ack && rx_nak == !exp_ack, req,
              {early, rx_ack, rx_nak}, {1'b0, exp_ack, !exp_ack});
        @(negedge clk);
        check(!rx_ack && !rx_nak, "R5", {rx_ack, rx_nak}, 0);
    endtask

    task automatic rx_raw(input logic [7:0] b, input bit s, input bit e);
        @(negedge clk);
        rx_valid = 1'b1; rx_sob = s; rx_eob = e; rx_byte = b;
    endtask

    task automatic rx_quiet_check(input int cyc, input string req);
        bit seen = 1'b0;
        @(negedge clk);
        rx_valid = 1'b0; rx_sob = 1'b0; rx_eob = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (rx_ack || rx_nak) seen = 1'b1;
        end
        check(!seen, req, seen, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!txo_valid && !txo_crc && !rx_ack && !rx_nak, "reset",
              {txo_valid, txo_crc, rx_ack, rx_nak}, 0);

        // R1 R2 R3 over several patterns; R4 via repeated blocks
        for (int p = 0; p < 4; p++) begin
            fill(p);
            tx_block(NB);
            tx_block(NB);
        end

        // R5 R8 sweep: clean frame then every single-bit flip
        for (int p = 0; p < 4; p++) begin
            fill(p);
            rx_frame(NB, -1, -1, 0, 1'b1, "R5");
            for (int f = 0; f < (NB + 4) * 8; f++)
                rx_frame(NB, f, -1, 0, 1'b0, "R8 single");
        end

        // R8 double-bit flips
        fill(0);
        for (int f = 0; f < (NB + 4) * 8; f += 3)
            rx_frame(NB, f, ((f + 11) % ((NB + 4) * 8) == f) ? (f + 1) : (f + 11) % ((NB + 4) * 8),
                     0, 1'b0, "R8 double");

        // R7 idle cycles between bytes
        fill(3);
        rx_frame(NB, -1, -1, 1, 1'b1, "R7 gaps");

        // R6 short and long blocks with correct code
        fill(0);
        rx_frame(NB - 1, -1, -1, 0, 1'b0, "R6 short");
        rx_frame(NB + 1, -1, -1, 0, 1'b0, "R6 long");
        rx_frame(1, -1, -1, 0, 1'b0, "R6 single");

        // R7 stray bytes with no open block
        rx_raw(8'h33, 1'b0, 1'b0);
        rx_raw(8'h44, 1'b0, 1'b1);
        rx_raw(8'h55, 1'b0, 1'b0);
        rx_raw(8'h66, 1'b0, 1'b0);
        rx_raw(8'h77, 1'b0, 1'b0);
        rx_raw(8'h88, 1'b0, 1'b0);
        rx_quiet_check(3, "R7 stray");
        fill(2);
        rx_frame(NB, -1, -1, 0, 1'b1, "R7 after stray");

        // R4 restart in data phase
        rx_raw(8'h12, 1'b1, 1'b0);
        rx_raw(8'h34, 1'b0, 1'b0);
        fill(1);
        rx_frame(NB, -1, -1, 0, 1'b1, "R4 data restart");

        // R4 restart inside check field
        rx_raw(8'h01, 1'b1, 1'b0);
        rx_raw(8'h02, 1'b0, 1'b0);
        rx_raw(8'h03, 1'b0, 1'b0);
        rx_raw(8'h04, 1'b0, 1'b1);
        rx_raw(8'hDE, 1'b0, 1'b0);
        rx_raw(8'hAD, 1'b0, 1'b0);
        rx_quiet_check(1, "R4 no pulse");
        fill(3);
        rx_frame(NB, -1, -1, 0, 1'b1, "R4 check restart");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule